// File: doc/BRIEF.md
# Bus Cycle Termination Resolver

This block is the master-side controller that decides how an asynchronous bus cycle finishes. A request latches an address, a direction and a size. The block then drives the address strobe and watches three active-high responder inputs: transfer acknowledge, bus error and halt. It samples them on each rising edge while the strobe is high, which is bus state N. After an acknowledge it samples them once more in the following state, N+2. The pair of samples resolves to exactly one outcome, reported as a one-clock pulse: normal completion, completion followed by a halt, a bus-error trap, or a retry of the same cycle.

While no responder input arrives, the block adds wait states and counts them. After a halted completion, or after a retry request, the block stalls until halt is negated. A retry then reissues the latched address, direction and size unchanged.

A mode input selects how a late bus error is treated. In base mode (`mode_enh` = 0), a bus error that arrives after an acknowledge is ignored. In enhanced mode (`mode_enh` = 1), the same late error becomes a trap, or a retry if halt is also asserted. The parameter `ENH_EN` removes the enhanced behaviour entirely when it is 0.

Top module: `busterm_resolver`

## Requirements
- R1: After reset, `addr_strobe`, `busy`, `stalled`, `wait_cnt` and all four outcome outputs are 0.
- R2: A `req_valid` seen while idle raises `addr_strobe` and `busy` on the next clock. `bus_addr`, `bus_write` and `bus_size` then equal the request values.
- R3: While the strobe is high and neither `xfer_ack` nor `bus_err` is seen, the strobe stays high and no outcome is reported. `wait_cnt` rises by one per clock from 0 and saturates at 2^WAIT_W-1.
- R4: `xfer_ack` at N, with `bus_err` low at N and N+2 and `halt_in` low at both, gives a `cyc_done` pulse on the clock after the N+2 edge.
- R5: `xfer_ack` at N with `bus_err` low and `halt_in` high at N or at N+2 gives `cyc_halted`. `stalled` then stays 1 and new requests are ignored until `halt_in` is sampled low.
- R6: `bus_err` with `halt_in` low at N gives `cyc_trap` on the next clock, whatever `xfer_ack` is.
- R7: `bus_err` with `halt_in` high at N gives `cyc_retry`. `stalled` holds until `halt_in` is low, and then the strobe reasserts with the original address, direction and size, even if the request inputs have changed.
- R8: After `xfer_ack` at N, a `bus_err` at N+2 with `halt_in` low gives `cyc_done` when `mode_enh`=0 and `cyc_trap` when `mode_enh`=1.
- R9: After `xfer_ack` at N, `bus_err` and `halt_in` both at N+2 give `cyc_done` when `mode_enh`=0 and `cyc_retry` when `mode_enh`=1.
- R10: At most one outcome output is high in any cycle, each pulse lasts one clock, and `addr_strobe` and `busy` are low in the cycle the outcome is high.
- R11: While idle, `xfer_ack` and `bus_err` have no effect: no outcome appears and the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_enh | input | 1 | 1 selects enhanced late-error handling |
| req_valid | input | 1 | Start a bus cycle (accepted only while idle) |
| req_addr | input | ADDR_W | Address of the requested cycle |
| req_write | input | 1 | 1 = write cycle |
| req_size | input | SIZE_W | Transfer size code |
| xfer_ack | input | 1 | Transfer acknowledge from responder |
| bus_err | input | 1 | Bus error from responder |
| halt_in | input | 1 | Halt request from system |
| addr_strobe | output | 1 | Address strobe, high during a cycle |
| bus_addr | output | ADDR_W | Latched cycle address |
| bus_write | output | 1 | Latched direction |
| bus_size | output | SIZE_W | Latched size |
| busy | output | 1 | High from strobe assertion until the outcome |
| stalled | output | 1 | Waiting for halt release after a halt or retry |
| wait_cnt | output | WAIT_W | Wait states inserted in the current attempt |
| cyc_done | output | 1 | Normal completion pulse |
| cyc_halted | output | 1 | Completion-then-halt pulse |
| cyc_trap | output | 1 | Bus-error trap pulse |
| cyc_retry | output | 1 | Retry pulse |

## Verification
The hardest situations to reach are the late cases. In these, a bus error, alone or together with halt, is applied only in the state after an acknowledge was accepted. The two modes must then give different outcomes for the same input pair. A table of vectors drives the N-state inputs after the strobe rises, and changes the inputs on the next clock only when the acknowledge took the block into its second sampling state. Each late vector is run in both modes.

The retry path also needs the request inputs corrupted during the stall. This shows that the reissued address comes from the held copy and not from the live request lines.

// File: rtl/busterm_pkg.sv
package busterm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SAMPLE,
      ST_LATE,
      ST_HOLD,
      ST_REWAIT
   } bt_state_e;

   typedef enum logic [2:0] {
      RS_NONE,
      RS_LATE,
      RS_DONE,
      RS_HALTED,
      RS_TRAP,
      RS_RETRY
   } bt_res_e;

   typedef struct packed {
      logic ack;
      logic berr;
      logic halt;
   } bt_ctl_s;

endpackage

// File: rtl/busterm_decode.sv
module busterm_decode
   import busterm_pkg::*;
#(
   parameter bit ENH_EN = 1'b1
)(
   input  bt_state_e phase,
   input  bt_ctl_s   ctl,
   input  logic      halt_seen,
   input  logic      mode_enh,
   output bt_res_e   res
);

   logic enh_eff;

   generate
      if (ENH_EN) begin : g_enh
         assign enh_eff = mode_enh;
      end else begin : g_base
         assign enh_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      res = RS_NONE;
      case (phase)
         ST_SAMPLE: begin
            if (ctl.berr)
               res = ctl.halt ? RS_RETRY : RS_TRAP;
            else if (ctl.ack)
               res = RS_LATE;
         end
         ST_LATE: begin
            if (ctl.berr)
               res = enh_eff ? (ctl.halt ? RS_RETRY : RS_TRAP) : RS_DONE;
            else if (halt_seen || ctl.halt)
               res = RS_HALTED;
            else
               res = RS_DONE;
         end
         default: res = RS_NONE;
      endcase
   end

endmodule

// File: rtl/busterm_req_hold.sv
module busterm_req_hold #(
   parameter int ADDR_W = 24,
   parameter int SIZE_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_write,
   input  logic [SIZE_W-1:0] in_size,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_write,
   output logic [SIZE_W-1:0] out_size
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_addr  <= '0;
         out_write <= 1'b0;
         out_size  <= '0;
      end else if (load) begin
         out_addr  <= in_addr;
         out_write <= in_write;
         out_size  <= in_size;
      end
   end

   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(out_addr) && $stable(out_write) && $stable(out_size));

endmodule

// File: rtl/busterm_wait_ctr.sv
module busterm_wait_ctr #(
   parameter int WAIT_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [WAIT_W-1:0] cnt
);

   localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && cnt != CNT_MAX)
         cnt <= cnt + 1'b1;
   end

   assert_wait_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && cnt == CNT_MAX) |=> cnt == CNT_MAX);

   assert_wait_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/busterm_resolver.sv
module busterm_resolver
   import busterm_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int SIZE_W = 2,
   parameter int WAIT_W = 4,
   parameter bit ENH_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_enh,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              xfer_ack,
   input  logic              bus_err,
   input  logic              halt_in,
   output logic              addr_strobe,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_write,
   output logic [SIZE_W-1:0] bus_size,
   output logic              busy,
   output logic              stalled,
   output logic [WAIT_W-1:0] wait_cnt,
   output logic              cyc_done,
   output logic              cyc_halted,
   output logic              cyc_trap,
   output logic              cyc_retry
);

   initial begin
      assert_param_addr: assert (ADDR_W > 0) else $error("ADDR_W must be positive");
      assert_param_size: assert (SIZE_W > 0) else $error("SIZE_W must be positive");
      assert_param_wait: assert (WAIT_W > 0 && WAIT_W <= 16) else $error("WAIT_W out of range");
   end

   bt_state_e state_q;
   bt_res_e   res;
   bt_ctl_s   ctl;
   logic      strobe_q;
   logic      halt_seen_q;
   logic      load_req;
   logic      reissue;
   logic      ctr_clr;
   logic      ctr_inc;
   logic      any_out;

   assign ctl = '{ack: xfer_ack, berr: bus_err, halt: halt_in};

   busterm_decode #(.ENH_EN(ENH_EN)) u_decode (
      .phase     (state_q),
      .ctl       (ctl),
      .halt_seen (halt_seen_q),
      .mode_enh  (mode_enh),
      .res       (res)
   );

   assign load_req = (state_q == ST_IDLE) && req_valid;
   assign reissue  = (state_q == ST_REWAIT) && !halt_in;

   busterm_req_hold #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_req),
      .in_addr   (req_addr),
      .in_write  (req_write),
      .in_size   (req_size),
      .out_addr  (bus_addr),
      .out_write (bus_write),
      .out_size  (bus_size)
   );

   assign ctr_clr = load_req || reissue;
   assign ctr_inc = (state_q == ST_SAMPLE) && (res == RS_NONE);

   busterm_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctr_clr),
      .inc   (ctr_inc),
      .cnt   (wait_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         strobe_q    <= 1'b0;
         halt_seen_q <= 1'b0;
         cyc_done    <= 1'b0;
         cyc_halted  <= 1'b0;
         cyc_trap    <= 1'b0;
         cyc_retry   <= 1'b0;
      end else begin
         cyc_done   <= 1'b0;
         cyc_halted <= 1'b0;
         cyc_trap   <= 1'b0;
         cyc_retry  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q  <= ST_SAMPLE;
                  strobe_q <= 1'b1;
               end
            end
            ST_SAMPLE: begin
               case (res)
                  RS_RETRY: begin
                     cyc_retry <= 1'b1;
                     strobe_q  <= 1'b0;
                     state_q   <= ST_REWAIT;
                  end
                  RS_TRAP: begin
                     cyc_trap <= 1'b1;
                     strobe_q <= 1'b0;
                     state_q  <= ST_IDLE;
                  end
                  RS_LATE: begin
                     halt_seen_q <= halt_in;
                     state_q     <= ST_LATE;
                  end
                  default: ;
               endcase
            end
            ST_LATE: begin
               strobe_q <= 1'b0;
               case (res)
                  RS_RETRY: begin
                     cyc_retry <= 1'b1;
                     state_q   <= ST_REWAIT;
                  end
                  RS_TRAP: begin
                     cyc_trap <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
                  RS_HALTED: begin
                     cyc_halted <= 1'b1;
                     state_q    <= ST_HOLD;
                  end
                  default: begin
                     cyc_done <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
               endcase
            end
            ST_HOLD: begin
               if (!halt_in)
                  state_q <= ST_IDLE;
            end
            ST_REWAIT: begin
               if (!halt_in) begin
                  state_q  <= ST_SAMPLE;
                  strobe_q <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign addr_strobe = strobe_q;
   assign busy        = strobe_q;
   assign stalled     = (state_q == ST_HOLD) || (state_q == ST_REWAIT);
   assign any_out     = cyc_done | cyc_halted | cyc_trap | cyc_retry;

   assert_outcome_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cyc_done, cyc_halted, cyc_trap, cyc_retry}));

   assert_outcome_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      any_out |=> !any_out);

   assert_strobe_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(addr_strobe) |-> any_out);

   assert_trap_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SAMPLE && bus_err && !halt_in) |=> cyc_trap);

   assert_wait_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SAMPLE && !xfer_ack && !bus_err) |=> addr_strobe && !any_out);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |=> !any_out);

   assert_stall_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |=> $stable(bus_addr));

endmodule

// File: tb/busterm_resolver_tb_top.sv
module busterm_resolver_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 24;
   localparam int SIZE_W = 2;
   localparam int WAIT_W = 4;
   localparam int WAIT_MAX = (1 << WAIT_W) - 1;
   localparam int NVEC = 16;

   // {mode, ack@N, berr@N, halt@N, berr@N+2, halt@N+2, outcome[1:0]}
   // outcome: 0 done, 1 halted, 2 trap, 3 retry
   localparam logic [7:0] VECS [NVEC] = '{
      8'b01000000, 8'b11000000, 8'b01010101, 8'b11010101,
      8'b00100010, 8'b01100010, 8'b10100010, 8'b00110011,
      8'b11110011, 8'b01001000, 8'b11001010, 8'b01001100,
      8'b11001111, 8'b11011111, 8'b01000101, 8'b01011100
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              mode_enh;
   logic              req_valid;
   logic [ADDR_W-1:0] req_addr;
   logic              req_write;
   logic [SIZE_W-1:0] req_size;
   logic              xfer_ack;
   logic              bus_err;
   logic              halt_in;
   logic              addr_strobe;
   logic [ADDR_W-1:0] bus_addr;
   logic              bus_write;
   logic [SIZE_W-1:0] bus_size;
   logic              busy;
   logic              stalled;
   logic [WAIT_W-1:0] wait_cnt;
   logic              cyc_done;
   logic              cyc_halted;
   logic              cyc_trap;
   logic              cyc_retry;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   busterm_resolver #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WAIT_W(WAIT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_enh(mode_enh), .req_valid(req_valid),
      .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
      .xfer_ack(xfer_ack), .bus_err(bus_err), .halt_in(halt_in),
      .addr_strobe(addr_strobe), .bus_addr(bus_addr), .bus_write(bus_write),
      .bus_size(bus_size), .busy(busy), .stalled(stalled), .wait_cnt(wait_cnt),
      .cyc_done(cyc_done), .cyc_halted(cyc_halted), .cyc_trap(cyc_trap),
      .cyc_retry(cyc_retry)
   );

   function automatic logic [3:0] outs();
      return {cyc_retry, cyc_trap, cyc_halted, cyc_done};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   task automatic run_vec(input int i);
      logic [7:0]        v;
      logic [ADDR_W-1:0] a;
      logic [3:0]        exp_oh;
      string             tag;
      v = VECS[i];
      a = {16'hA5C3, 8'(i)};
      exp_oh = 4'b0001 << v[1:0];
      if (v[5])      tag = v[4] ? "R7" : "R6";
      else if (v[3]) tag = v[2] ? "R9" : "R8";
      else if (v[1:0] == 2'd1) tag = "R5";
      else tag = "R4";

      @(negedge clk);
      mode_enh  = v[7];
      req_valid = 1'b1;
      req_addr  = a;
      req_write = a[0];
      req_size  = a[2:1];
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2", "strobe", 32'(addr_strobe), 32'd1);
      chk("R2", "busy", 32'(busy), 32'd1);
      chk("R2", "addr", 32'(bus_addr), 32'(a));
      chk("R2", "write/size", 32'({bus_write, bus_size}), 32'({a[0], a[2:1]}));
      req_addr  = ~a;
      req_write = ~a[0];
      req_size  = ~a[2:1];

      xfer_ack = v[6];
      bus_err  = v[5];
      halt_in  = v[4];
      @(negedge clk);
      if (v[6] && !v[5]) begin
         chk(tag, "no outcome at N", 32'(outs()), 32'd0);
         bus_err = v[3];
         halt_in = v[2];
         @(negedge clk);
      end
      chk(tag, "outcome", 32'(outs()), 32'(exp_oh));
      chk("R10", "strobe/busy low at outcome", 32'({addr_strobe, busy}), 32'd0);
      xfer_ack = 1'b0;
      bus_err  = 1'b0;

      if (v[1:0] == 2'd1) begin
         chk("R5", "stalled after halt", 32'(stalled), 32'd1);
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         chk("R5", "request ignored while halted", 32'({addr_strobe, stalled}), 32'b01);
         halt_in = 1'b0;
         @(negedge clk);
         chk("R5", "released", 32'({addr_strobe, stalled}), 32'b00);
      end else if (v[1:0] == 2'd3) begin
         chk("R7", "stalled after retry", 32'(stalled), 32'd1);
         @(negedge clk);
         chk("R7", "held while halt", 32'({addr_strobe, stalled}), 32'b01);
         halt_in = 1'b0;
         @(negedge clk);
         chk("R7", "reissue strobe", 32'(addr_strobe), 32'd1);
         chk("R7", "reissue addr", 32'(bus_addr), 32'(a));
         chk("R7", "reissue write/size", 32'({bus_write, bus_size}), 32'({a[0], a[2:1]}));
         xfer_ack = 1'b1;
         @(negedge clk);
         @(negedge clk);
         chk("R4", "retried cycle completes", 32'(outs()), 32'b0001);
         xfer_ack = 1'b0;
      end else begin
         halt_in = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      rst_n     = 1'b0;
      mode_enh  = 1'b0;
      req_valid = 1'b0;
      req_addr  = '0;
      req_write = 1'b0;
      req_size  = '0;
      xfer_ack  = 1'b0;
      bus_err   = 1'b0;
      halt_in   = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "reset outputs", 32'({addr_strobe, busy, stalled, outs()}), 32'd0);
      chk("R1", "reset wait count", 32'(wait_cnt), 32'd0);
      rst_n = 1'b1;

      // R11: responder inputs while idle
      @(negedge clk);
      xfer_ack = 1'b1;
      bus_err  = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R11", "idle ignores ack/err", 32'({addr_strobe, outs()}), 32'd0);
      end
      xfer_ack = 1'b0;
      bus_err  = 1'b0;

      for (int i = 0; i < NVEC; i++) run_vec(i);

      // R3: wait states and saturation
      @(negedge clk);
      mode_enh  = 1'b0;
      req_valid = 1'b1;
      req_addr  = 24'h00BEEF;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3", "wait count starts", 32'(wait_cnt), 32'd0);
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         chk("R3", "wait count", 32'(wait_cnt), 32'((k > WAIT_MAX) ? WAIT_MAX : k));
         chk("R3", "strobe held no outcome", 32'({addr_strobe, outs()}), 32'b10000);
      end
      xfer_ack = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R4", "done after waits", 32'(outs()), 32'b0001);
      xfer_ack = 1'b0;
      @(negedge clk);
      chk("R10", "single pulse", 32'(outs()), 32'd0);

      summary();
   end

endmodule